// File: doc/BRIEF.md
# Two-Bit Branch Target Buffer

This block predicts the next fetch address. It is a direct-mapped table of 16 entries. Each entry holds a valid bit, the upper address bits of a branch (the tag), the branch's target address, and a 2-bit confidence counter. Bits [5:2] of a 32-bit PC select the entry. The two byte-offset bits are never used. A lookup compares the stored tag with bits [31:6] of the fetch PC. The lookup returns the stored target when the tag matches and the counter leans towards taken. In every other case it returns PC+4.

Branch resolution logic, outside this block, reports each resolved branch on the update port. It sends the branch PC, the outcome and the target. If the indexed entry already holds that branch, the update trains the counter and rewrites the target. If not, the update takes over the entry. It writes the new tag and target and seeds the counter from the outcome. The table changes only at the clock edge, so a lookup in the same cycle as an update sees the contents from before that update.

Each counter is a four-state machine. The states are STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11).

Transitions on a taken outcome:
- STRONG_NT goes to WEAK_NT, and WEAK_NT goes to WEAK_T (step-up).
- WEAK_T goes to STRONG_T.
- STRONG_T stays at STRONG_T (saturate-high).

Transitions on a not-taken outcome:
- STRONG_T goes to WEAK_T, and WEAK_T goes to WEAK_NT (step-down).
- WEAK_NT goes to STRONG_NT.
- STRONG_NT stays at STRONG_NT (saturate-low).

Allocation jumps straight to WEAK_T on a taken outcome and to WEAK_NT on a not-taken outcome.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup reports a miss and returns PC+4.
- R2: The entry index is PC bits [5:2] and the tag is PC bits [31:6]. A PC with the same index but a different tag is a miss.
- R3: A lookup drives next_pc to the stored target when it hits and the counter is 10 or 11. Otherwise next_pc is PC+4, wrapping modulo 2^32, and predict_taken is 0.
- R4: An update that misses the indexed entry allocates it. It writes tag and target and sets the counter to 10 on taken or 01 on not taken.
- R5: An update that hits moves the counter one step toward the outcome. On taken it saturates at 11. On not taken it saturates at 00.
- R6: An update that hits rewrites the stored target with the reported target.
- R7: From a strong state, a single opposite outcome keeps the prediction unchanged. Two consecutive opposite outcomes flip it.
- R8: When a lookup and an update address the same index in one cycle, the lookup returns the old contents. The new contents are visible from the next cycle.
- R9: While upd_valid is 0, the update inputs have no effect on any entry.
- R10: An allocation on a tag conflict replaces the previous branch. The old PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hit | output | 1 | Indexed entry is valid and its tag matches |
| lk_predict_taken | output | 1 | Hit and counter is 10 or 11 |
| lk_next_pc | output | 32 | Predicted next fetch address |
| upd_valid | input | 1 | Resolved branch report present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | 32 | Resolved target address |

## Verification
The assertions assume that update inputs are known values in any cycle where upd_valid is 1. They also assume at most one update per cycle, and that reset is held for at least one clock edge before the first update. The stimulus changes inputs only on the falling clock edge. It drops upd_valid between reports and keeps the PC byte-offset bits at zero. Its mix of two tags per index forces both training and conflict allocation through every counter state. The expected next PC is computed arithmetically from a per-index tag, target and counter kept by the bench.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    typedef enum logic [1:0] {
        WR_NONE  = 2'b00,
        WR_ALLOC = 2'b01,
        WR_TRAIN = 2'b10
    } wr_kind_e;

endpackage

// File: rtl/btb_ctr_fsm.sv
module btb_ctr_fsm
    import btb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alloc_en,
    input  logic       train_en,
    input  logic       outcome,
    output logic [1:0] state_o
);

    ctr_state_e state_q;
    ctr_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CTR_WEAK_NT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (alloc_en) begin
            state_d = outcome ? CTR_WEAK_T : CTR_WEAK_NT;
        end else if (train_en) begin
            unique case (state_q)
                CTR_STRONG_NT: state_d = outcome ? CTR_WEAK_NT  : CTR_STRONG_NT;
                CTR_WEAK_NT:   state_d = outcome ? CTR_WEAK_T   : CTR_STRONG_NT;
                CTR_WEAK_T:    state_d = outcome ? CTR_STRONG_T : CTR_WEAK_NT;
                CTR_STRONG_T:  state_d = outcome ? CTR_STRONG_T : CTR_WEAK_T;
                default:       state_d = CTR_WEAK_NT;
            endcase
        end
    end

    // outputs
    always_comb begin
        state_o = state_q;
    end

    // R4
    alloc_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && outcome) |=> (state_q == CTR_WEAK_T));
    // R4
    alloc_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !outcome) |=> (state_q == CTR_WEAK_NT));
    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !alloc_en && outcome && state_q == CTR_STRONG_T) |=> (state_q == CTR_STRONG_T));
    // R5
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !alloc_en && !outcome && state_q == CTR_STRONG_NT) |=> (state_q == CTR_STRONG_NT));
    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (train_en && !alloc_en && outcome && state_q != CTR_STRONG_T)
        |=> (2'(state_q) == 2'($past(state_q)) + 2'd1));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!train_en && !alloc_en) |=> $stable(state_q));

endmodule

// File: rtl/btb_entry.sv
module btb_entry
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic             upd_taken,
    input  logic [PC_W-1:0]  upd_target,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [PC_W-1:0]  target_o,
    output logic [1:0]       ctr_o
);

    logic             valid_q;
    logic [TAG_W-1:0] tag_q;
    logic [PC_W-1:0]  target_q;
    wr_kind_e         kind;
    logic             match;

    always_comb begin
        match = valid_q && (tag_q == upd_tag);
        if (!sel)       kind = WR_NONE;
        else if (match) kind = WR_TRAIN;
        else            kind = WR_ALLOC;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            tag_q    <= '0;
            target_q <= '0;
        end else begin
            unique case (kind)
                WR_ALLOC: begin
                    valid_q  <= 1'b1;
                    tag_q    <= upd_tag;
                    target_q <= upd_target;
                end
                WR_TRAIN: target_q <= upd_target;
                default: ;
            endcase
        end
    end

    btb_ctr_fsm u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (kind == WR_ALLOC),
        .train_en (kind == WR_TRAIN),
        .outcome  (upd_taken),
        .state_o  (ctr_o)
    );

    always_comb begin
        valid_o  = valid_q;
        tag_o    = tag_q;
        target_o = target_q;
    end

    // R6
    target_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (target_q == $past(upd_target)));
    // R4
    alloc_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel |=> (valid_q && tag_q == $past(upd_tag)));
    // R9
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> ($stable(tag_q) && $stable(target_q) && $stable(valid_q)));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26
) (
    input  logic [PC_W-1:0]                lk_pc,
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  tag_i,
    input  logic [ENTRIES-1:0][PC_W-1:0]   target_i,
    input  logic [ENTRIES-1:0][1:0]        ctr_i,
    output logic                           hit_o,
    output logic                           taken_o,
    output logic [PC_W-1:0]                next_pc_o
);

    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [PC_W-1:0]  seq_pc;

    always_comb begin
        idx       = lk_pc[IDX_W+1:2];
        tag       = lk_pc[PC_W-1:IDX_W+2];
        seq_pc    = lk_pc + PC_W'(4);
        hit_o     = valid_i[idx] && (tag_i[idx] == tag);
        taken_o   = hit_o && ctr_i[idx][1];
        next_pc_o = taken_o ? target_i[idx] : seq_pc;
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int ENTRIES = 16,
    parameter int PC_W    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_predict_taken,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0]                upd_idx;
    logic [TAG_W-1:0]                upd_tag;
    logic [ENTRIES-1:0]              valid_w;
    logic [ENTRIES-1:0][TAG_W-1:0]   tag_w;
    logic [ENTRIES-1:0][PC_W-1:0]    target_w;
    logic [ENTRIES-1:0][1:0]         ctr_w;

    always_comb begin
        upd_idx = upd_pc[IDX_W+1:2];
        upd_tag = upd_pc[PC_W-1:IDX_W+2];
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        btb_entry #(
            .PC_W  (PC_W),
            .TAG_W (TAG_W)
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .sel        (upd_valid && (upd_idx == IDX_W'(i))),
            .upd_tag    (upd_tag),
            .upd_taken  (upd_taken),
            .upd_target (upd_target),
            .valid_o    (valid_w[i]),
            .tag_o      (tag_w[i]),
            .target_o   (target_w[i]),
            .ctr_o      (ctr_w[i])
        );
    end

    btb_lookup #(
        .ENTRIES (ENTRIES),
        .PC_W    (PC_W),
        .IDX_W   (IDX_W),
        .TAG_W   (TAG_W)
    ) u_lookup (
        .lk_pc     (lk_pc),
        .valid_i   (valid_w),
        .tag_i     (tag_w),
        .target_i  (target_w),
        .ctr_i     (ctr_w),
        .hit_o     (lk_hit),
        .taken_o   (lk_predict_taken),
        .next_pc_o (lk_next_pc)
    );

    // R1
    reset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit);
    // R3
    miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_predict_taken |-> (lk_next_pc == lk_pc + PC_W'(4)));
    // R3
    taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_predict_taken |-> lk_hit);

endmodule

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic        lk_predict_taken;
    logic [31:0] lk_next_pc;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    bit          m_valid [16];
    logic [25:0] m_tag   [16];
    logic [31:0] m_tgt   [16];
    int          m_ctr   [16];
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    btb_predictor dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .lk_pc            (lk_pc),
        .lk_hit           (lk_hit),
        .lk_predict_taken (lk_predict_taken),
        .lk_next_pc       (lk_next_pc),
        .upd_valid        (upd_valid),
        .upd_pc           (upd_pc),
        .upd_taken        (upd_taken),
        .upd_target       (upd_target)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic m_update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
        int i;
        i = int'(pc[5:2]);
        if (m_valid[i] && m_tag[i] == pc[31:6]) begin
            m_ctr[i] = tk ? ((m_ctr[i] == 3) ? 3 : m_ctr[i] + 1)
                          : ((m_ctr[i] == 0) ? 0 : m_ctr[i] - 1);
        end else begin
            m_valid[i] = 1'b1;
            m_tag[i]   = pc[31:6];
            m_ctr[i]   = tk ? 2 : 1;
        end
        m_tgt[i] = tgt;
    endtask

    // check lookup at the current time (between negedge and posedge)
    task automatic check_lookup(input logic [31:0] pc, input string req);
        int   i;
        bit   e_hit;
        bit   e_tk;
        logic [31:0] e_pc;
        i     = int'(pc[5:2]);
        lk_pc = pc;
        #1;
        e_hit = m_valid[i] && (m_tag[i] == pc[31:6]);
        e_tk  = e_hit && (m_ctr[i] >= 2);
        e_pc  = e_tk ? m_tgt[i] : pc + 32'd4;
        tests++;
        if (lk_hit !== e_hit || lk_predict_taken !== e_tk || lk_next_pc !== e_pc) begin
            fails++;
            $display("FAIL %s pc=%h: hit/taken/next actual %0b/%0b/%h expected %0b/%0b/%h",
                     req, pc, lk_hit, lk_predict_taken, lk_next_pc, e_hit, e_tk, e_pc);
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = pc;
        upd_taken  = tk;
        upd_target = tgt;
        @(negedge clk);
        upd_valid = 1'b0;
        m_update(pc, tk, tgt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every index misses after reset, including the wrap case of R3
        for (int i = 0; i < 16; i++) check_lookup({26'h155_5555 ^ 26'(i), 4'(i), 2'b00}, "R1");
        check_lookup(32'hFFFF_FFFC, "R3 wrap");

        // R4: allocation seeds the counter from the outcome
        do_update(32'h0000_1004, 1'b1, 32'h0000_2000);
        check_lookup(32'h0000_1004, "R4 taken");
        do_update(32'h0000_1008, 1'b0, 32'h0000_3000);
        check_lookup(32'h0000_1008, "R4 not-taken");

        // R7: strong taken needs two not-taken outcomes to flip
        do_update(32'h0000_1004, 1'b1, 32'h0000_2000);  // 11
        check_lookup(32'h0000_1004, "R5 up");
        do_update(32'h0000_1004, 1'b0, 32'h0000_2000);  // 10
        check_lookup(32'h0000_1004, "R7 one miss");
        do_update(32'h0000_1004, 1'b0, 32'h0000_2000);  // 01
        check_lookup(32'h0000_1004, "R7 two misses");

        // R6: training rewrites the target
        do_update(32'h0000_1008, 1'b1, 32'h0000_4440);  // 01 -> 10
        check_lookup(32'h0000_1008, "R6");

        // R2 / R10: alias with a different tag misses, then replaces
        check_lookup(32'h0000_5008, "R2 alias");
        do_update(32'h0000_5008, 1'b1, 32'h0000_6000);
        check_lookup(32'h0000_5008, "R10 new");
        check_lookup(32'h0000_1008, "R10 old");

        // R8: same-cycle lookup sees old contents
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h0000_7010; upd_taken = 1'b1; upd_target = 32'h0000_8000;
        check_lookup(32'h0000_7010, "R8 old");
        @(negedge clk);
        upd_valid = 1'b0;
        m_update(32'h0000_7010, 1'b1, 32'h0000_8000);
        check_lookup(32'h0000_7010, "R8 new");

        // R9: update fields change with upd_valid low
        @(negedge clk);
        upd_pc = 32'h0000_7010; upd_taken = 1'b0; upd_target = 32'hDEAD_BEE0;
        @(negedge clk);
        check_lookup(32'h0000_7010, "R9");

        // sweep: two tags per index, pseudo-random outcomes, all counter states
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] pc;
            logic [31:0] alias_pc;
            rng = next_rng(rng);
            pc       = {25'h0, rng[0], 4'(rng[7:4]), 2'b00} | 32'h0040_0000;
            alias_pc = pc ^ 32'h0000_0040;
            rng = next_rng(rng);
            do_update(pc, rng[3] | rng[9], {rng[31:2], 2'b00});
            check_lookup(pc, "R5 sweep");
            check_lookup(alias_pc, "R2 sweep");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule